// File: doc/BRIEF.md
# Flash Write Status Reporter

This block produces what a host observes on the data bus and on the ready/busy line while a two-bank flash array carries out an internal word program or erase. A single-cycle start pulse, qualified by an operation kind, a word address and a program word, launches the operation. An internal busy timer then holds the operation for a parameterised number of clock cycles. Each operation kind has its own count, which stands in for the typical durations of about 14 µs (word program), 18 ms (sector or block erase) and 70 ms (chip erase). The timer reloads from that count on every accepted start.

While the operation runs, reads of the bank under write return a status word instead of array data. Bit 7 is a polarity flag: the inverted bit 7 of the word being programmed, or 0 during any erase. Bit 6 inverts on every read of that bank. Reads of the other bank return array contents, so code can keep executing from it. The ready/busy indication is modelled as an open-drain driver: one output enable that, when set, pulls the line low.

The array is a small behavioural store: per bank, the low `MODEL_LOWB` address bits select a word and higher bits alias. Programming can only clear bits. An erase restores ones across the modelled words of the target bank, or of both banks for a chip erase. Synchronous reset aborts any operation without committing it and leaves every modelled word erased.

Top module: `flash_status_reporter`

## Requirements
- R1: An accepted start holds the block busy for exactly `PROG_CYC` cycles for kind 0 (program), `ERASE_CYC` for kinds 1 and 2 (sector and block erase) and `CHIP_CYC` for kind 3 (chip erase), counted from the clock edge that samples the start.
- R2: During a program, a read of the busy bank returns bit 7 equal to the inverse of bit 7 of the program word. Bits 15..8 and 5..0 read 0.
- R3: During any erase, a read of a busy bank returns 0 on bit 7 and 0 on bits 15..8 and 5..0.
- R4: Bit 6 of the status word reads 0 on the first read after a start. It inverts after every clock cycle with a read of a busy bank. Cycles that read the idle bank, or that do no read, leave it unchanged.
- R5: While one bank is busy, a read of the other bank returns that bank's array contents.
- R6: On completion, a program leaves the word as old AND new. A sector or block erase sets every modelled word of the target bank to FFFFh. A chip erase sets all words of both banks to FFFFh. Reads then return array data.
- R7: A start that arrives while busy is ignored. The running operation, its duration and the array are not affected.
- R8: `rb_oe` (pull ready/busy low) is 1 only while busy with `ce_n` low and reset deasserted. It is 0 whenever `ce_n` is high.
- R9: `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both low. A read cycle is a clock cycle with both low.
- R10: Reset clears busy, releases `rb_oe` in the same cycle, drops the running operation without committing it, and leaves all modelled words at FFFFh.
- R11: Addresses below `BANK_SPLIT` (default 40000h) belong to bank 0; addresses at or above it belong to bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts a running operation |
| start | input | 1 | One-cycle request to launch an operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | input | 20 | Word address of the operation |
| op_data | input | 16 | Word to program |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | 20 | Read word address |
| rd_data | output | 16 | Status word or array data |
| dq_oe | output | 1 | Data bus drive enable |
| rb_oe | output | 1 | Ready/busy pull-down enable (line low when 1) |

## Verification
The bench reads the busy bank back to back and then reads the idle bank between two busy reads. A toggle flop that also flipped on idle-bank reads, or that failed to reset on a new start, would show the wrong bit 6 on the third status read. It programs a word whose bit 7 is 1, so a polarity flag that forgets the inversion returns 80h where 00h is due. It also reads the word at 3FFFFh while 40000h is being programmed, which exposes an off-by-one bank boundary as a status word in place of data. Further cases are a second start during a program, reset in the middle of a program, and deselecting the chip while busy. Respectively, a design that queued the second request, committed the aborted word, or kept pulling the line low would show up as a longer busy count, a cleared word, or a set `rb_oe`.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

    localparam int unsigned FSR_AW = 20;
    localparam int unsigned FSR_DW = 16;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e              kind;
        logic [FSR_AW-1:0]     addr;
        logic [FSR_DW-1:0]     data;
    } op_req_t;

    // Bank number of a word address: 1 at or above the split point.
    function automatic logic bank_of(input logic [FSR_AW-1:0] a,
                                     input logic [FSR_AW-1:0] split);
        return a >= split;
    endfunction

    // Banks occupied by an operation, bit n set for bank n.
    function automatic logic [1:0] busy_banks(input op_req_t r,
                                              input logic [FSR_AW-1:0] split);
        if (r.kind == OP_CHIP)
            return 2'b11;
        return bank_of(r.addr, split) ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/fsr_busy_timer.sv
`timescale 1ns/1ps
module fsr_busy_timer
    import fsr_pkg::*;
#(
    parameter int unsigned PROG_CYC  = 28,
    parameter int unsigned ERASE_CYC = 36,
    parameter int unsigned CHIP_CYC  = 140
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  op_kind_e kind,
    output logic     busy,
    output logic     done
);
    localparam int unsigned MAX_PE = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int unsigned MAXC   = (MAX_PE > CHIP_CYC) ? MAX_PE : CHIP_CYC;
    localparam int unsigned CW     = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len;

    always_comb begin
        unique case (kind)
            OP_PROG: len = CW'(PROG_CYC);
            OP_CHIP: len = CW'(CHIP_CYC);
            default: len = CW'(ERASE_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/fsr_array_model.sv
`timescale 1ns/1ps
module fsr_array_model
    import fsr_pkg::*;
#(
    parameter logic [FSR_AW-1:0] BANK_SPLIT = 20'h40000,
    parameter int unsigned       MODEL_LOWB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  op_req_t           op,
    input  logic [FSR_AW-1:0] rd_addr,
    output logic [FSR_DW-1:0] rd_word
);
    localparam int unsigned BANK_WORDS = 1 << MODEL_LOWB;
    localparam int unsigned WORDS      = 2 * BANK_WORDS;
    localparam int unsigned IW         = MODEL_LOWB + 1;

    logic [FSR_DW-1:0] mem [WORDS];

    function automatic logic [IW-1:0] word_idx(input logic [FSR_AW-1:0] a);
        return {bank_of(a, BANK_SPLIT), a[MODEL_LOWB-1:0]};
    endfunction

    logic [IW-1:0] wr_idx;
    logic          wr_bank;

    assign wr_idx  = word_idx(op.addr);
    assign wr_bank = bank_of(op.addr, BANK_SPLIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++)
                mem[w] <= '1;
        end else if (commit) begin
            for (int w = 0; w < WORDS; w++) begin
                unique case (op.kind)
                    OP_PROG: if (IW'(w) == wr_idx) mem[w] <= mem[w] & op.data;
                    OP_CHIP: mem[w] <= '1;
                    default: if ((w >= BANK_WORDS) == wr_bank) mem[w] <= '1;
                endcase
            end
        end
    end

    assign rd_word = mem[word_idx(rd_addr)];

endmodule

// File: rtl/fsr_status_unit.sv
`timescale 1ns/1ps
module fsr_status_unit
    import fsr_pkg::*;
#(
    parameter logic [FSR_AW-1:0] BANK_SPLIT = 20'h40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              busy,
    input  op_req_t           act,
    input  logic              rd_en,
    input  logic [FSR_AW-1:0] rd_addr,
    input  logic [FSR_DW-1:0] array_word,
    output logic [FSR_DW-1:0] rd_data,
    output logic              hit_busy,
    output logic              tog
);
    logic              tog_q;
    logic [1:0]        banks;
    logic [FSR_DW-1:0] stat_word;

    assign banks    = busy_banks(act, BANK_SPLIT);
    assign hit_busy = busy && banks[bank_of(rd_addr, BANK_SPLIT)];

    always_ff @(posedge clk) begin
        if (rst || accept)
            tog_q <= 1'b0;
        else if (rd_en && hit_busy)
            tog_q <= ~tog_q;
    end

    always_comb begin
        stat_word    = '0;
        stat_word[6] = tog_q;
        stat_word[7] = (act.kind == OP_PROG) ? ~act.data[7] : 1'b0;
    end

    assign rd_data = hit_busy ? stat_word : array_word;
    assign tog     = tog_q;

endmodule

// File: rtl/flash_status_reporter.sv
`timescale 1ns/1ps
module flash_status_reporter
    import fsr_pkg::*;
#(
    parameter logic [FSR_AW-1:0] BANK_SPLIT = 20'h40000,
    parameter int unsigned       MODEL_LOWB = 4,
    parameter int unsigned       PROG_CYC   = 28,
    parameter int unsigned       ERASE_CYC  = 36,
    parameter int unsigned       CHIP_CYC   = 140
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic [FSR_AW-1:0] op_addr,
    input  logic [FSR_DW-1:0] op_data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [FSR_AW-1:0] rd_addr,
    output logic [FSR_DW-1:0] rd_data,
    output logic              dq_oe,
    output logic              rb_oe
);
    logic              busy;
    logic              done;
    logic              accept;
    logic              rd_en;
    logic              hit_busy;
    logic              tog;
    logic [FSR_DW-1:0] array_word;
    op_req_t           req;
    op_req_t           act;

    assign req    = '{kind: op_kind_e'(op_kind), addr: op_addr, data: op_data};
    assign accept = start && !busy;
    assign rd_en  = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst)
            act <= '0;
        else if (accept)
            act <= req;
    end

    fsr_busy_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .CHIP_CYC  (CHIP_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .kind (req.kind),
        .busy (busy),
        .done (done)
    );

    fsr_array_model #(
        .BANK_SPLIT (BANK_SPLIT),
        .MODEL_LOWB (MODEL_LOWB)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .commit  (done),
        .op      (act),
        .rd_addr (rd_addr),
        .rd_word (array_word)
    );

    fsr_status_unit #(
        .BANK_SPLIT (BANK_SPLIT)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .busy       (busy),
        .act        (act),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .array_word (array_word),
        .rd_data    (rd_data),
        .hit_busy   (hit_busy),
        .tog        (tog)
    );

    assign dq_oe = rd_en;
    assign rb_oe = busy && !ce_n && !rst;

endmodule

// File: rtl/flash_status_reporter_chk.sv
`timescale 1ns/1ps
module flash_status_reporter_chk
    import fsr_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    start,
    input logic    ce_n,
    input logic    oe_n,
    input logic    dq_oe,
    input logic    rb_oe,
    input logic    busy,
    input logic    hit_busy,
    input logic    tog,
    input op_req_t act
);
    logic rd;
    assign rd = !ce_n && !oe_n;

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_tog_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (rd && hit_busy) |=> (tog != $past(tog)));

    assert_tog_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rd && !hit_busy && !(start && !busy)) |=> $stable(tog));

    assert_op_held_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(act));

    assert_rb_desel_R8: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !rb_oe);

    assert_dq_off_R9: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !dq_oe);

    assert_rb_reset_R10: assert property (@(posedge clk)
        rst |-> !rb_oe);

endmodule

bind flash_status_reporter flash_status_reporter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .rb_oe    (rb_oe),
    .busy     (busy),
    .hit_busy (hit_busy),
    .tog      (tog),
    .act      (act)
);

// File: tb/flash_status_reporter_test.sv
`timescale 1ns/1ps
module flash_status_reporter_test;

    localparam int unsigned PROG_N  = 28;
    localparam int unsigned ERASE_N = 36;
    localparam int unsigned CHIP_N  = 140;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [19:0] op_addr = '0;
    logic [15:0] op_data = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [19:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        dq_oe;
    logic        rb_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] sh [32];

    always #2.5 clk = ~clk;

    flash_status_reporter #(
        .BANK_SPLIT (20'h40000),
        .MODEL_LOWB (4),
        .PROG_CYC   (PROG_N),
        .ERASE_CYC  (ERASE_N),
        .CHIP_CYC   (CHIP_N)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .ce_n(ce_n), .oe_n(oe_n),
        .rd_addr(rd_addr), .rd_data(rd_data), .dq_oe(dq_oe), .rb_oe(rb_oe)
    );

    // kind, op address, program word, check address, expected word
    localparam logic [73:0] VEC [9] = '{
        {2'd0, 20'h00005, 16'h1234, 20'h00005, 16'h1234},
        {2'd0, 20'h00005, 16'hFF0F, 20'h00005, 16'h1204},
        {2'd0, 20'h40003, 16'h5A5A, 20'h40003, 16'h5A5A},
        {2'd1, 20'h00100, 16'h0000, 20'h00005, 16'hFFFF},
        {2'd0, 20'h7FFFF, 16'h8000, 20'h7FFFF, 16'h8000},
        {2'd2, 20'h40000, 16'h0000, 20'h40003, 16'hFFFF},
        {2'd0, 20'h3FFFF, 16'h00AA, 20'h3FFFF, 16'h00AA},
        {2'd0, 20'h40000, 16'h0F0F, 20'h40000, 16'h0F0F},
        {2'd3, 20'h00000, 16'h0000, 20'h3FFFF, 16'hFFFF}
    };

    function automatic int sidx(input logic [19:0] a);
        return (a >= 20'h40000 ? 16 : 0) + int'(a[3:0]);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic shadow_commit(input logic [1:0] k, input logic [19:0] a, input logic [15:0] d);
        for (int w = 0; w < 32; w++) begin
            if (k == 2'd0 && w == sidx(a)) sh[w] = sh[w] & d;
            else if (k == 2'd3) sh[w] = 16'hFFFF;
            else if (k != 2'd0 && (w >= 16) == (a >= 20'h40000)) sh[w] = 16'hFFFF;
        end
    endtask

    task automatic read_at(input logic [19:0] a, input string tag, input logic [15:0] exp);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; rd_addr = a;
        #1;
        check(tag, {16'h0, rd_data}, {16'h0, exp});
        oe_n = 1'b1;
    endtask

    // Launch one operation and probe status, toggle and idle-bank reads.
    task automatic run_op(input logic [1:0] k, input logic [19:0] a, input logic [15:0] d);
        logic [15:0] st0;
        logic [19:0] idle;
        int          busy_n;
        int          want;
        busy_n = 0;
        st0  = (k == 2'd0) ? {8'h00, ~d[7], 7'h00} : 16'h0000;
        idle = (a >= 20'h40000) ? 20'h00008 : 20'h40008;
        want = (k == 2'd0) ? PROG_N : (k == 2'd3) ? CHIP_N : ERASE_N;
        @(negedge clk);
        start = 1'b1; op_kind = k; op_addr = a; op_data = d; ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            oe_n = 1'b1;
            if (i == 0 || i == 1 || i == 3) begin oe_n = 1'b0; rd_addr = a; end
            if (i == 2 && k != 2'd3)       begin oe_n = 1'b0; rd_addr = idle; end
            #1;
            if (!rb_oe) break;
            busy_n++;
            if (i == 0) check(k == 2'd0 ? "R2 status word" : "R3 status word", {16'h0, rd_data}, {16'h0, st0});
            if (i == 1) check("R4 toggle second read", {16'h0, rd_data}, {16'h0, st0 | 16'h0040});
            if (i == 2 && k != 2'd3) check("R5 idle bank read", {16'h0, rd_data}, {16'h0, sh[sidx(idle)]});
            if (i == 3) check("R4 toggle held over idle read", {16'h0, rd_data}, {16'h0, st0});
            @(negedge clk);
        end
        oe_n = 1'b1;
        check("R1 busy cycles", busy_n, want);
        shadow_commit(k, a, d);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary_and_end();
    end

    initial begin
        for (int w = 0; w < 32; w++) sh[w] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        #1;
        check("R8 rb_oe idle after reset", rb_oe, 0);
        check("R9 dq_oe off when deselected", dq_oe, 0);
        read_at(20'h12345, "R10 erased after reset", 16'hFFFF);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; #1;
        check("R9 dq_oe on with both enables low", dq_oe, 1);
        oe_n = 1'b1; #1;
        check("R9 dq_oe off with oe_n high", dq_oe, 0);

        // Vector table
        for (int v = 0; v < 9; v++) begin
            run_op(VEC[v][73:72], VEC[v][71:52], VEC[v][51:36]);
            read_at(VEC[v][35:16], "R6 word after completion", VEC[v][15:0]);
        end

        // Bank boundary, deselect and ignored second start
        begin
            int busy_n;
            busy_n = 0;
            @(negedge clk);
            start = 1'b1; op_kind = 2'd0; op_addr = 20'h40001; op_data = 16'h0000; ce_n = 1'b0;
            @(negedge clk);
            start = 1'b0; oe_n = 1'b0; rd_addr = 20'h3FFFF; #1;
            busy_n++;
            check("R11 word below split is idle bank", {16'h0, rd_data}, {16'h0, 16'hFFFF});
            @(negedge clk);
            rd_addr = 20'h40000; #1;
            busy_n++;
            check("R11 word at split is busy bank", {16'h0, rd_data}, 32'h0080);
            @(negedge clk);
            oe_n = 1'b1; ce_n = 1'b1; #1;
            busy_n++;
            check("R8 rb_oe released when deselected", rb_oe, 0);
            @(negedge clk);
            ce_n = 1'b0;
            start = 1'b1; op_kind = 2'd0; op_addr = 20'h00002; op_data = 16'h0000;
            #1; busy_n++;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 1000; i++) begin
                #1;
                if (!rb_oe) break;
                busy_n++;
                @(negedge clk);
            end
            check("R7 busy length unchanged by second start", busy_n, PROG_N);
            read_at(20'h00002, "R7 second start not executed", 16'hFFFF);
            read_at(20'h40001, "R6 first program committed", 16'h0000);
        end

        // Reset in the middle of a program
        @(negedge clk);
        start = 1'b1; op_kind = 2'd0; op_addr = 20'h00003; op_data = 16'h0000; ce_n = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1; #1;
        check("R10 rb_oe released during reset", rb_oe, 0);
        @(negedge clk);
        rst = 1'b0; #1;
        check("R10 not busy after reset", rb_oe, 0);
        for (int w = 0; w < 32; w++) sh[w] = 16'hFFFF;
        read_at(20'h00003, "R10 aborted program not committed", 16'hFFFF);
        run_op(2'd0, 20'h00003, 16'h0000);
        read_at(20'h00003, "R6 program after reset", 16'h0000);

        summary_and_end();
    end

endmodule